// File: doc/BRIEF.md
# Iterative Carry-Register Adder

This unit adds two words without a full-width combinational carry path. Carries are held in a visible carry register and move one bit per elementary step, with a fixed number of steps per clock. An issue strobe takes the top-of-stack operand and the second stack operand. A later collect strobe copies the current result register onto the top-of-stack output. Software chooses how long to wait between the two.

On the clock edge that takes an issue, the unit loads the operands and applies `FIRST_STEPS` elementary steps. Every later edge without an issue applies `NEXT_STEPS` more. One step sets the result to result XOR carry and the carry to (result AND carry) shifted left by one. The bit shifted out of the top sets a sticky carry-out flag. `exact_o` goes high when the carry register is empty. At that point the result register holds the true sum modulo 2^WIDTH. A collect made while carries are still pending returns a wrong word.

Top module: `iter_carry_adder`

## Requirements
- R1: After a synchronous reset, `tos_o` is 0, `exact_o` is 1 and `cout_o` is 0.
- R2: An issue loads the operands and applies FIRST_STEPS steps at that edge. A collect latches the current result register into `tos_o` at the next edge.
- R3: Each edge without an issue applies NEXT_STEPS further steps. Once FIRST_STEPS + k*NEXT_STEPS >= WIDTH steps are done, `exact_o` is 1.
- R4: `exact_o` is 1 exactly when the result register equals (tos_i + sos_i) mod 2^WIDTH. A collect made while `exact_o` is 0 yields a value different from that sum.
- R5: Operands with no common set bit give their bitwise OR on a collect made right after the issue.
- R6: `cout_o` is cleared by each issue and is set by any carry leaving bit WIDTH-1. When `exact_o` is 1, it equals bit WIDTH of the full sum.
- R7: While `exact_o` is 1 and no issue arrives, the result, `exact_o` and `cout_o` stay unchanged.
- R8: An issue that arrives while carries are pending discards the old add and starts the new one.
- R9: When collect and issue share an edge, `tos_o` receives the result of the earlier add.
- R10: `tos_o` changes only on an edge where collect is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Start an add with tos_i and sos_i |
| collect_i | input | 1 | Latch the result register into tos_o |
| tos_i | input | WIDTH | Top-of-stack operand, loads the carry register |
| sos_i | input | WIDTH | Second stack operand, loads the result register |
| tos_o | output | WIDTH | Collected result |
| exact_o | output | 1 | Carry register is zero |
| cout_o | output | 1 | Sticky carry out of the top bit |

## Verification
The checker follows a reference sum of the last issued operands. On every cycle it checks that result, carry register and carry-out together still add up to that sum. It also checks that an exact collect returns that sum, that `tos_o` holds between collects, that the state is frozen once exact, and that a collect on an issue edge returns the prior result. Only the bench scenarios show how many clocks a given carry chain needs. They also cover the boundary chains just under and just over the first-clock step budget, a replaced add in flight, and the reset state.

// File: rtl/iter_carry_pkg.sv
package iter_carry_pkg;
  localparam int unsigned DEF_WIDTH       = 16;
  localparam int unsigned DEF_FIRST_STEPS = 8;
  localparam int unsigned DEF_NEXT_STEPS  = 12;
endpackage

// File: rtl/carry_step_stage.sv
module carry_step_stage #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] res_i,
  input  logic [WIDTH-1:0] car_i,
  output logic [WIDTH-1:0] res_o,
  output logic [WIDTH-1:0] car_o,
  output logic             co_o
);
  logic [WIDTH-1:0] gen;

  always_comb begin
    gen   = res_i & car_i;
    res_o = res_i ^ car_i;
    car_o = {gen[WIDTH-2:0], 1'b0};
    co_o  = gen[WIDTH-1];
  end
endmodule

// File: rtl/carry_step_chain.sv
module carry_step_chain #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned STEPS = 8
) (
  input  logic [WIDTH-1:0] res_i,
  input  logic [WIDTH-1:0] car_i,
  output logic [WIDTH-1:0] res_o,
  output logic [WIDTH-1:0] car_o,
  output logic             co_o
);
  logic [WIDTH-1:0] res_s [STEPS+1];
  logic [WIDTH-1:0] car_s [STEPS+1];
  logic [STEPS-1:0] co_s;

  assign res_s[0] = res_i;
  assign car_s[0] = car_i;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    carry_step_stage #(.WIDTH(WIDTH)) u_stage (
      .res_i(res_s[g]),
      .car_i(car_s[g]),
      .res_o(res_s[g+1]),
      .car_o(car_s[g+1]),
      .co_o (co_s[g])
    );
  end

  assign res_o = res_s[STEPS];
  assign car_o = car_s[STEPS];
  assign co_o  = |co_s;
endmodule

// File: rtl/iter_carry_adder.sv
module iter_carry_adder
  import iter_carry_pkg::*;
#(
  parameter int unsigned WIDTH       = DEF_WIDTH,
  parameter int unsigned FIRST_STEPS = DEF_FIRST_STEPS,
  parameter int unsigned NEXT_STEPS  = DEF_NEXT_STEPS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_i,
  input  logic             collect_i,
  input  logic [WIDTH-1:0] tos_i,
  input  logic [WIDTH-1:0] sos_i,
  output logic [WIDTH-1:0] tos_o,
  output logic             exact_o,
  output logic             cout_o
);
  logic [WIDTH-1:0] res_q, car_q, tos_q;
  logic             co_q;
  logic [WIDTH-1:0] ld_res, ld_car, rn_res, rn_car;
  logic             ld_co, rn_co;

  // Steps applied on the issue edge, starting from the raw operands.
  carry_step_chain #(.WIDTH(WIDTH), .STEPS(FIRST_STEPS)) u_load (
    .res_i(sos_i),
    .car_i(tos_i),
    .res_o(ld_res),
    .car_o(ld_car),
    .co_o (ld_co)
  );

  // Steps applied on every later edge, starting from the held state.
  carry_step_chain #(.WIDTH(WIDTH), .STEPS(NEXT_STEPS)) u_run (
    .res_i(res_q),
    .car_i(car_q),
    .res_o(rn_res),
    .car_o(rn_car),
    .co_o (rn_co)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      car_q <= '0;
      co_q  <= 1'b0;
      tos_q <= '0;
    end else begin
      if (collect_i) tos_q <= res_q;
      if (issue_i) begin
        res_q <= ld_res;
        car_q <= ld_car;
        co_q  <= ld_co;
      end else begin
        res_q <= rn_res;
        car_q <= rn_car;
        co_q  <= co_q | rn_co;
      end
    end
  end

  assign tos_o   = tos_q;
  assign exact_o = ~|car_q;
  assign cout_o  = co_q;
endmodule

// File: rtl/iter_carry_adder_chk.sv
module iter_carry_adder_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             issue_i,
  input logic             collect_i,
  input logic [WIDTH-1:0] tos_i,
  input logic [WIDTH-1:0] sos_i,
  input logic [WIDTH-1:0] tos_o,
  input logic             exact_o,
  input logic             cout_o,
  input logic [WIDTH-1:0] res_q,
  input logic [WIDTH-1:0] car_q
);
  logic [WIDTH:0] ref_sum;
  logic           ref_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_sum <= '0;
      ref_ok  <= 1'b0;
    end else if (issue_i) begin
      ref_sum <= {1'b0, tos_i} + {1'b0, sos_i};
      ref_ok  <= 1'b1;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (tos_o == '0 && exact_o && !cout_o));

  a_r10_hold_output: assert property (@(posedge clk) disable iff (rst)
    !collect_i |=> $stable(tos_o));

  a_r7_frozen_when_exact: assert property (@(posedge clk) disable iff (rst)
    (exact_o && !issue_i) |=> (exact_o && $stable(res_q) && $stable(cout_o)));

  a_r9_collect_on_issue: assert property (@(posedge clk) disable iff (rst)
    (collect_i && issue_i) |=> tos_o == $past(res_q));

  // R2, R3: the held state always adds up to the reference sum.
  a_r3_sum_invariant: assert property (@(posedge clk) disable iff (rst)
    ref_ok |-> (({cout_o, res_q} + {1'b0, car_q}) == ref_sum));

  a_r4_exact_collect: assert property (@(posedge clk) disable iff (rst)
    (ref_ok && collect_i && !issue_i && exact_o) |=> tos_o == $past(ref_sum[WIDTH-1:0]));

  a_r6_carry_out: assert property (@(posedge clk) disable iff (rst)
    (ref_ok && exact_o) |-> cout_o == ref_sum[WIDTH]);
endmodule

bind iter_carry_adder iter_carry_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .issue_i(issue_i), .collect_i(collect_i),
  .tos_i(tos_i), .sos_i(sos_i), .tos_o(tos_o), .exact_o(exact_o),
  .cout_o(cout_o), .res_q(res_q), .car_q(car_q)
);

// File: tb/test_iter_carry_adder.sv
`timescale 1ns/1ps
module test_iter_carry_adder;
  localparam int W  = 16;
  localparam int NV = 9;
  localparam int FIRST = 8;
  localparam int NEXT  = 12;

  localparam logic [W-1:0] V_TOS [NV] = '{16'h00F0, 16'hFFFF, 16'hFFFF, 16'h1234,
                                           16'h007F, 16'h00FF, 16'h7FFF, 16'h8000, 16'hABCD};
  localparam logic [W-1:0] V_SOS [NV] = '{16'h0F00, 16'h0001, 16'h0001, 16'h4321,
                                           16'h0001, 16'h0001, 16'h0001, 16'h8000, 16'h5432};
  localparam int V_WAIT [NV] = '{0, 0, 1, 0, 0, 0, 1, 0, 2};
  localparam bit V_EXACT [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

  logic clk = 1'b0, rst = 1'b1, issue_i = 1'b0, collect_i = 1'b0;
  logic [W-1:0] tos_i = '0, sos_i = '0, tos_o;
  logic exact_o, cout_o;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  iter_carry_adder #(.WIDTH(W), .FIRST_STEPS(FIRST), .NEXT_STEPS(NEXT)) i_iter_carry_adder (
    .clk(clk), .rst(rst), .issue_i(issue_i), .collect_i(collect_i),
    .tos_i(tos_i), .sos_i(sos_i), .tos_o(tos_o), .exact_o(exact_o), .cout_o(cout_o)
  );

  task automatic chk(input bit ok, input string req, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W:0] sum;
    logic ex, co;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(tos_o == '0, "R1 tos_o", {1'b0, tos_o}, '0);
    chk(exact_o == 1'b1, "R1 exact_o", {16'd0, exact_o}, 17'd1);
    chk(cout_o == 1'b0, "R1 cout_o", {16'd0, cout_o}, 17'd0);

    // Table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      sum = {1'b0, V_TOS[i]} + {1'b0, V_SOS[i]};
      issue_i = 1'b1; tos_i = V_TOS[i]; sos_i = V_SOS[i];
      @(negedge clk);
      issue_i = 1'b0;
      repeat (V_WAIT[i]) @(negedge clk);
      collect_i = 1'b1;
      ex = exact_o; co = cout_o;
      @(negedge clk);
      collect_i = 1'b0;
      chk(ex == V_EXACT[i], "R3 exact after wait", {16'd0, ex}, {16'd0, V_EXACT[i]});
      chk((tos_o == sum[W-1:0]) == ex, "R4 exact predicts match", {1'b0, tos_o}, sum);
      if (ex) chk(co == sum[W], "R6 carry out", {16'd0, co}, {16'd0, sum[W]});
      if ((V_TOS[i] & V_SOS[i]) == '0)
        chk(tos_o == (V_TOS[i] | V_SOS[i]), "R5 disjoint OR", {1'b0, tos_o},
            {1'b0, V_TOS[i] | V_SOS[i]});
    end

    // R8: replace an add in flight
    issue_i = 1'b1; tos_i = 16'hFFFF; sos_i = 16'h0001;
    @(negedge clk);
    tos_i = 16'h0002; sos_i = 16'h0001;
    @(negedge clk);
    issue_i = 1'b0; collect_i = 1'b1;
    chk(exact_o == 1'b1, "R8 exact after replace", {16'd0, exact_o}, 17'd1);
    @(negedge clk);
    collect_i = 1'b0;
    chk(tos_o == 16'h0003, "R8 replaced sum", {1'b0, tos_o}, 17'h0003);
    chk(cout_o == 1'b0, "R8 carry out cleared", {16'd0, cout_o}, 17'd0);

    // R10: new add runs, output holds without collect
    issue_i = 1'b1; tos_i = 16'h00FF; sos_i = 16'h0001;
    @(negedge clk);
    issue_i = 1'b0;
    chk(tos_o == 16'h0003, "R10 hold 1", {1'b0, tos_o}, 17'h0003);
    @(negedge clk);
    chk(tos_o == 16'h0003, "R10 hold 2", {1'b0, tos_o}, 17'h0003);
    // R7: idle cycles after exact leave the result unchanged
    repeat (3) @(negedge clk);
    chk(exact_o == 1'b1, "R7 still exact", {16'd0, exact_o}, 17'd1);

    // R9: collect on the issue edge returns the earlier result
    issue_i = 1'b1; collect_i = 1'b1; tos_i = 16'h0010; sos_i = 16'h0020;
    @(negedge clk);
    issue_i = 1'b0;
    chk(tos_o == 16'h0100, "R9 old result on issue edge", {1'b0, tos_o}, 17'h0100);
    @(negedge clk);
    collect_i = 1'b0;
    chk(tos_o == 16'h0030, "R2 new result next collect", {1'b0, tos_o}, 17'h0030);
    // R7: a repeated collect once exact gives the same word
    repeat (2) @(negedge clk);
    collect_i = 1'b1;
    @(negedge clk);
    collect_i = 1'b0;
    chk(tos_o == 16'h0030, "R7 repeat collect", {1'b0, tos_o}, 17'h0030);

    // R1: reset again clears everything
    issue_i = 1'b1; tos_i = 16'hFFFF; sos_i = 16'h0001;
    @(negedge clk);
    issue_i = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(tos_o == '0 && exact_o && !cout_o, "R1 second reset",
        {cout_o, tos_o}, 17'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule